// File: doc/BRIEF.md
# Programmable Read-Latency Data Pipeline

This block reproduces the read-data timing of a synchronous DRAM device. A read command is sampled together with its first data word. The following burst beats arrive one per clock on a separate valid stream. Each beat comes out on the data bus a programmed number of clocks later: one, two or three. The bus output enable turns on one clock before the first beat is valid and stays on until the cycle after the last beat. When two reads follow each other without a gap, it stays on without a break.

The latency comes from a small setting register. The register rejects reserved codes. It also rejects any change while beats are still in flight. In both cases it raises a one-cycle error pulse and keeps the old setting, so the timing never shifts in the middle of a transfer.

Top module: `sdr_read_latency_pipe`

## Requirements
- R1: After synchronous reset, dq_oe, dq_valid and lat_err are low and the latency is two clocks.
- R2: lat_code is three bits. Values 1, 2 and 3 select a latency of that many clocks. A beat sampled at edge n (rd_cmd with rd_data, or beat_vld with beat_data) appears on dq_data with dq_valid high in the cycle after edge n+m, where m is the latency.
- R3: Beats sampled on consecutive edges leave on consecutive cycles, in order, all with the same latency offset.
- R4: dq_oe goes high in the cycle after edge n+m-1, one cycle ahead of the first valid beat. With latency 1 this is the cycle after the edge that samples the read.
- R5: dq_oe is high in every cycle where dq_valid is high. It drops in the cycle after the last valid beat. It stays high across back-to-back reads and across a one-cycle gap between beats.
- R6: A write (lat_wr) with a reserved code (0, 4, 5, 6 or 7) leaves the latency unchanged. lat_err is high for exactly the cycle after that write.
- R7: A write is ignored if a beat is sampled on the same edge, or if a beat was sampled within the previous three edges and is not yet delivered. The latency stays unchanged and lat_err pulses for one cycle. An accepted write takes effect for reads sampled on later edges, with lat_err low.
- R8: dq_data is zero in every cycle where dq_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_wr | input | 1 | Write strobe for the latency setting |
| lat_code | input | 3 | Requested latency code |
| rd_cmd | input | 1 | Read command; marks the first beat |
| rd_data | input | DATA_W | Data word sampled with the read command |
| beat_vld | input | 1 | Valid for a following burst beat |
| beat_data | input | DATA_W | Data of a following burst beat |
| dq_oe | output | 1 | Bus output enable |
| dq_data | output | DATA_W | Delayed data word |
| dq_valid | output | 1 | Data word valid |
| lat_err | output | 1 | One-cycle pulse for a rejected latency write |

## Verification
The bench runs bursts of several lengths at each of the three latencies. A tap picked off by one stage would shift every beat by a cycle and the scoreboard would see it. It places bursts back to back, and with one-cycle and two-cycle gaps. An enable built from the current beat alone would come on late or drop between beats. An enable built without a hold cycle would fail to bridge the one-cycle gap. Reserved codes are written, and so are codes while beats are still in the pipeline. A register that accepted either one would move the next burst's arrival cycle. The bench then reads back each setting through the timing of a following read.

// File: rtl/sdr_rdpipe_pkg.sv
package sdr_rdpipe_pkg;
  localparam int MAX_LAT = 3;
  localparam int CODE_W  = 3;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c >= CODE_W'(1)) && (c <= CODE_W'(MAX_LAT));
  endfunction
endpackage

// File: rtl/rdp_lat_reg.sv
module rdp_lat_reg
  import sdr_rdpipe_pkg::*;
#(
  parameter int RST_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CODE_W-1:0] code,
  input  logic              busy,
  output logic [CODE_W-1:0] lat,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat <= CODE_W'(RST_LAT);
      err <= 1'b0;
    end else begin
      err <= 1'b0;
      if (wr) begin
        if (busy || !code_ok(code)) err <= 1'b1;
        else                        lat <= code;
      end
    end
  end
endmodule

// File: rtl/rdp_delay_line.sv
module rdp_delay_line #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_vld,
  input  logic [DATA_W-1:0]            in_data,
  output logic [DEPTH:0]               tap_vld,
  output logic [DEPTH:0][DATA_W-1:0]   tap_data
);
  assign tap_vld[0]  = in_vld;
  assign tap_data[0] = in_data;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= tap_vld[g-1];
    end
    always_ff @(posedge clk) begin
      d_q <= tap_data[g-1];
    end
    assign tap_vld[g]  = v_q;
    assign tap_data[g] = d_q;
  end
endmodule

// File: rtl/rdp_out_stage.sv
module rdp_out_stage
  import sdr_rdpipe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CODE_W-1:0]          lat,
  input  logic [DEPTH:0]             tap_vld,
  input  logic [DEPTH:0][DATA_W-1:0] tap_data,
  output logic                       oe,
  output logic                       valid,
  output logic [DATA_W-1:0]          data
);
  logic              sel_vld;
  logic              pre_vld;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    sel_vld  = 1'b0;
    pre_vld  = 1'b0;
    sel_data = '0;
    for (int i = 1; i <= DEPTH; i++) begin
      if (lat == CODE_W'(i)) begin
        sel_vld  = tap_vld[i];
        pre_vld  = tap_vld[i-1];
        sel_data = tap_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe    <= 1'b0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      oe    <= sel_vld | pre_vld;
      valid <= sel_vld;
      data  <= sel_vld ? sel_data : '0;
    end
  end
endmodule

// File: rtl/sdr_read_latency_pipe.sv
module sdr_read_latency_pipe
  import sdr_rdpipe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RST_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lat_wr,
  input  logic [2:0]        lat_code,
  input  logic              rd_cmd,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              beat_vld,
  input  logic [DATA_W-1:0] beat_data,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_data,
  output logic              dq_valid,
  output logic              lat_err
);
  localparam int DEPTH = MAX_LAT;

  logic                       in_vld;
  logic [DATA_W-1:0]          in_data;
  logic [DEPTH:0]             tap_vld;
  logic [DEPTH:0][DATA_W-1:0] tap_data;
  logic [CODE_W-1:0]          cur_lat;
  logic                       busy;

  assign in_vld  = rd_cmd | beat_vld;
  assign in_data = rd_cmd ? rd_data : beat_data;
  assign busy    = (|tap_vld) | dq_valid;

  rdp_lat_reg #(.RST_LAT(RST_LAT)) u_lat (
    .clk(clk), .rst(rst), .wr(lat_wr), .code(lat_code),
    .busy(busy), .lat(cur_lat), .err(lat_err)
  );

  rdp_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .tap_vld(tap_vld), .tap_data(tap_data)
  );

  rdp_out_stage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_out (
    .clk(clk), .rst(rst), .lat(cur_lat), .tap_vld(tap_vld),
    .tap_data(tap_data), .oe(dq_oe), .valid(dq_valid), .data(dq_data)
  );
endmodule

// File: rtl/sdr_read_latency_pipe_chk.sv
module sdr_read_latency_pipe_chk (
  input logic       clk,
  input logic       rst,
  input logic       lat_wr,
  input logic [2:0] lat_code,
  input logic       rd_cmd,
  input logic       beat_vld,
  input logic       dq_oe,
  input logic       dq_valid,
  input logic       lat_err,
  input logic [2:0] cur_lat
);
  a_r2_lat1_timing: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && cur_lat == 3'd1) |-> ##2 dq_valid);
  a_r2_lat2_timing: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && cur_lat == 3'd2) |-> ##3 dq_valid);
  a_r2_lat3_timing: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && cur_lat == 3'd3) |-> ##4 dq_valid);
  a_r4_lat1_oe_same_edge: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && cur_lat == 3'd1) |=> dq_oe);
  a_r4_oe_leads_valid: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && !dq_valid) |=> dq_valid);
  a_r5_valid_under_oe: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> dq_oe);
  a_r6_reserved_rejected: assert property (@(posedge clk) disable iff (rst)
    (lat_wr && !(lat_code inside {3'd1, 3'd2, 3'd3})) |=> (lat_err && $stable(cur_lat)));
  a_r7_busy_rejected: assert property (@(posedge clk) disable iff (rst)
    (lat_wr && (rd_cmd || beat_vld || dq_valid)) |=> (lat_err && $stable(cur_lat)));
endmodule

bind sdr_read_latency_pipe sdr_read_latency_pipe_chk u_chk (
  .clk(clk), .rst(rst), .lat_wr(lat_wr), .lat_code(lat_code),
  .rd_cmd(rd_cmd), .beat_vld(beat_vld), .dq_oe(dq_oe),
  .dq_valid(dq_valid), .lat_err(lat_err), .cur_lat(cur_lat)
);

// File: tb/sdr_read_latency_pipe_test.sv
module sdr_read_latency_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lat_wr = 1'b0;
  logic [2:0]    lat_code = 3'd0;
  logic          rd_cmd = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          beat_vld = 1'b0;
  logic [DW-1:0] beat_data = '0;
  logic          dq_oe, dq_valid, lat_err;
  logic [DW-1:0] dq_data;

  typedef struct { int t; logic [DW-1:0] d; } exp_t;
  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int bench_lat = 2;
  bit running = 1'b0;

  sdr_read_latency_pipe #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .lat_wr(lat_wr), .lat_code(lat_code),
    .rd_cmd(rd_cmd), .rd_data(rd_data), .beat_vld(beat_vld),
    .beat_data(beat_data), .dq_oe(dq_oe), .dq_data(dq_data),
    .dq_valid(dq_valid), .lat_err(lat_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: scoreboard compare at the falling edge
  always @(negedge clk) begin
    if (running) begin
      bit oe_exp;
      oe_exp = (q.size() > 0 && (q[0].t == cyc || q[0].t == cyc + 1)) ||
               (q.size() > 1 && q[1].t == cyc + 1);
      check(dq_oe == oe_exp, "R4 R5 output enable", int'(dq_oe), int'(oe_exp));
      if (dq_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 R3 unexpected beat", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.t == cyc, "R2 R3 beat arrival cycle", cyc, e.t);
          check(dq_data == e.d, "R2 R3 beat data", int'(dq_data), int'(e.d));
        end
      end else begin
        check(dq_data == '0, "R8 idle data zero", int'(dq_data), 0);
        if (q.size() > 0)
          check(q[0].t != cyc, "R2 missing beat", 0, 1);
      end
    end
  end

  task automatic drive_beat(input bit first, input logic [DW-1:0] d);
    exp_t e;
    @(negedge clk);
    lat_wr = 1'b0;
    rd_cmd = first; rd_data = first ? d : '0;
    beat_vld = !first; beat_data = first ? '0 : d;
    e.t = cyc + 1 + bench_lat; e.d = d;
    q.push_back(e);
  endtask

  task automatic burst(input int len, input logic [DW-1:0] base);
    for (int k = 0; k < len; k++) drive_beat(k == 0, base + DW'(k));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd_cmd = 1'b0; beat_vld = 1'b0; lat_wr = 1'b0;
    end
  endtask

  task automatic wait_empty();
    idle(1);
    while (q.size() != 0) @(negedge clk);
    idle(5);
  endtask

  task automatic write_lat(input logic [2:0] code, input bit exp_err, input string req);
    @(negedge clk);
    lat_wr = 1'b1; lat_code = code;
    @(negedge clk);
    lat_wr = 1'b0;
    check(lat_err == exp_err, req, int'(lat_err), int'(exp_err));
    if (!exp_err) bench_lat = int'(code);
    @(negedge clk);
    check(lat_err == 1'b0, {req, " pulse length"}, int'(lat_err), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dq_oe == 1'b0, "R1 reset oe", int'(dq_oe), 0);
    check(dq_valid == 1'b0, "R1 reset valid", int'(dq_valid), 0);
    check(lat_err == 1'b0, "R1 reset err", int'(lat_err), 0);
    running = 1'b1;

    // R1: default latency of two, R2/R3 burst
    burst(4, 32'h1000); wait_empty();

    // latency 1
    write_lat(3'd1, 1'b0, "R7 accept lat1");
    burst(3, 32'h2000); wait_empty();
    burst(1, 32'h2100); wait_empty();

    // latency 3 with back-to-back reads, R5
    write_lat(3'd3, 1'b0, "R7 accept lat3");
    burst(4, 32'h3000); burst(2, 32'h3100); wait_empty();

    // gaps of one and two idle cycles, R5
    burst(2, 32'h4000); idle(1); burst(2, 32'h4100); wait_empty();
    burst(2, 32'h4200); idle(2); burst(2, 32'h4300); wait_empty();

    // reserved codes, R6
    write_lat(3'd0, 1'b1, "R6 reserved 0");
    write_lat(3'd5, 1'b1, "R6 reserved 5");
    write_lat(3'd7, 1'b1, "R6 reserved 7");
    burst(2, 32'h5000); wait_empty();

    // write during burst input, R7
    drive_beat(1'b1, 32'h6000);
    drive_beat(1'b0, 32'h6001);
    lat_wr = 1'b1; lat_code = 3'd1;
    drive_beat(1'b0, 32'h6002);
    check(lat_err == 1'b1, "R7 write with beat", int'(lat_err), 1);
    // write while beats still in pipeline, R7
    @(negedge clk);
    rd_cmd = 1'b0; beat_vld = 1'b0; lat_wr = 1'b1; lat_code = 3'd2;
    @(negedge clk);
    lat_wr = 1'b0;
    check(lat_err == 1'b1, "R7 write with pending beats", int'(lat_err), 1);
    wait_empty();
    burst(3, 32'h7000); wait_empty();

    // back to latency 2 with mixed bursts
    write_lat(3'd2, 1'b0, "R7 accept lat2");
    burst(3, 32'h8000); burst(1, 32'h8100); idle(1); burst(2, 32'h8200);
    wait_empty();
    check(q.size() == 0, "R3 all beats delivered", q.size(), 0);

    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule